// File: doc/BRIEF.md
# Byte-Wide Bus Interface for a 16-Bit DAC Register Pair

This block lets an 8-bit processor drive a 16-bit digital-to-analog converter over I/O write cycles. A write is recognised when the active-low I/O-request and write strobes are both low at once. The combined strobe is brought into the clock domain, and its leading edge is turned into one command per bus cycle. The low three bits of the I/O address choose the command. The upper bits must match a configured base address.

The converter code is double-buffered. Two byte writes build a 16-bit input word. A separate update write copies that word to the output register that drives the converter. Two clear commands force both the input word and the output register to a zero code: one to unipolar zero and one to bipolar (midscale) zero. The data bus is ignored on update and clear writes. A one-cycle pulse marks every update or clear of the output register.

The address and data buses must stay stable while the strobes are asserted.

Top module: `bytebus_dac_if`

## Requirements
- R1: A command is taken only when `iorq_n` and `wr_n` are both low together. Either strobe low on its own has no effect.
- R2: Offset 0 loads data into bits 7:0 of the input word, and offset 1 loads data into bits 15:8. Neither load changes `dac_code` or pulses `dac_upd`.
- R3: A write to offset 2 or to offset 3 copies the input word into `dac_code`.
- R4: A write to offset 4 sets both `dac_code` and the input word to 0x0000 (unipolar zero).
- R5: A write to offset 5 sets both `dac_code` and the input word to 0x8000 (bipolar zero, offset binary).
- R6: The value on `data` during writes to offsets 2 through 5 has no effect on the result.
- R7: Writes to offsets 6 and 7 are ignored.
- R8: The offset is `addr[2:0]`. A write is ignored when `addr[15:3]` differs from `BASE_ADDR[15:3]`.
- R9: One bus cycle gives exactly one command, however many clocks the strobes stay low.
- R10: `dac_upd` is high for exactly one clock after each update or clear. It stays low otherwise, and `dac_code` changes only together with it.
- R11: Reset (`rst_n` low) sets the input word and `dac_code` to 0x0000, with `dac_upd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | I/O address |
| data | input | 8 | Write data bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dac_code | output | 16 | Code driven to the converter |
| dac_upd | output | 1 | One-clock pulse on each update or clear |

## Verification
The assertions check these on every cycle:
- an update copies the buffered word;
- each clear lands on its zero code in both registers;
- byte loads leave the output alone;
- the update pulse lasts one clock;
- the output never changes without that pulse;
- a detected strobe edge never repeats on consecutive clocks.

Only the bench's scenarios can show the rest:
- that a lone strobe or a foreign address does nothing;
- that offsets 6 and 7 are inert;
- that the data bus is ignored on command writes;
- that a long-held strobe gives a single command.

The bench shows these by sweeping all eight offsets and many byte patterns against an arithmetic model.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_LOAD_LO = 3'd1,
        CMD_LOAD_HI = 3'd2,
        CMD_UPDATE  = 3'd3,
        CMD_CLR_UNI = 3'd4,
        CMD_CLR_BIP = 3'd5
    } dac_cmd_e;

    localparam int unsigned OFS_W = 3;

endpackage

// File: rtl/dacif_strobe_sync.sv
module dacif_strobe_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic edge_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = strobe_i;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.prev = sync_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign edge_o = sync_q.chain[LAST] & ~sync_q.prev;

    // R9: a single bus cycle cannot produce back-to-back command edges
    a_r9_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0040
) (
    input  logic              edge_i,
    input  logic [ADDR_W-1:0] addr_i,
    output dac_cmd_e          cmd_o
);
    localparam int unsigned HI_W = ADDR_W - OFS_W;

    logic [HI_W-1:0]  base_hi;
    logic [OFS_W-1:0] offset;
    logic             hit;

    assign base_hi = BASE_ADDR[ADDR_W-1:OFS_W];
    assign offset  = addr_i[OFS_W-1:0];
    assign hit     = edge_i && (addr_i[ADDR_W-1:OFS_W] == base_hi);

    always_comb begin
        cmd_o = CMD_NONE;
        if (hit) begin
            unique case (offset[2:1])
                2'b00: cmd_o = offset[0] ? CMD_LOAD_HI : CMD_LOAD_LO;
                2'b01: cmd_o = CMD_UPDATE;
                2'b10: cmd_o = offset[0] ? CMD_CLR_BIP : CMD_CLR_UNI;
                default: cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned DAC_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dac_cmd_e         cmd_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [DAC_W-1:0] dac_o,
    output logic             upd_o
);
    localparam logic [DAC_W-1:0] UNI_ZERO = '0;
    localparam logic [DAC_W-1:0] BIP_ZERO = {1'b1, {(DAC_W-1){1'b0}}};

    typedef struct packed {
        logic [DAC_W-1:0] in_word;
        logic [DAC_W-1:0] dac_word;
        logic             upd;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.upd = 1'b0;
        unique case (cmd_i)
            CMD_LOAD_LO: regs_d.in_word[BYTE_W-1:0]     = data_i;
            CMD_LOAD_HI: regs_d.in_word[DAC_W-1:BYTE_W] = data_i;
            CMD_UPDATE: begin
                regs_d.dac_word = regs_q.in_word;
                regs_d.upd      = 1'b1;
            end
            CMD_CLR_UNI: begin
                regs_d.in_word  = UNI_ZERO;
                regs_d.dac_word = UNI_ZERO;
                regs_d.upd      = 1'b1;
            end
            CMD_CLR_BIP: begin
                regs_d.in_word  = BIP_ZERO;
                regs_d.dac_word = BIP_ZERO;
                regs_d.upd      = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dac_o = regs_q.dac_word;
    assign upd_o = regs_q.upd;

    a_r3_update_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_UPDATE) |=> (dac_o == $past(regs_q.in_word)));

    a_r4_clear_unipolar: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_CLR_UNI) |=> (dac_o == UNI_ZERO && regs_q.in_word == UNI_ZERO));

    a_r5_clear_bipolar: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_CLR_BIP) |=> (dac_o == BIP_ZERO && regs_q.in_word == BIP_ZERO));

    a_r2_load_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD_LO || cmd_i == CMD_LOAD_HI) |=> ($stable(dac_o) && !upd_o));

    a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    a_r10_change_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(dac_o));

endmodule

// File: rtl/bytebus_dac_if.sv
module bytebus_dac_if
    import dacif_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned DAC_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [15:0] BASE_ADDR   = 16'h0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    input  logic              iorq_n,
    input  logic              wr_n,
    output logic [DAC_W-1:0]  dac_code,
    output logic              dac_upd
);
    logic     access;
    logic     edge_w;
    dac_cmd_e cmd_w;

    // R1: both strobes must be low together
    assign access = ~iorq_n & ~wr_n;

    dacif_strobe_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(access),
        .edge_o  (edge_w)
    );

    dacif_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) decode_i (
        .edge_i(edge_w),
        .addr_i(addr),
        .cmd_o (cmd_w)
    );

    dacif_regs #(
        .BYTE_W(BYTE_W),
        .DAC_W (DAC_W)
    ) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd_w),
        .data_i(data),
        .dac_o (dac_code),
        .upd_o (dac_upd)
    );

endmodule

// File: tb/bytebus_dac_if_tb.sv
module bytebus_dac_if_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        iorq_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] dac_code;
    logic        dac_upd;

    int n_checks = 0;
    int n_fail = 0;
    int pulses = 0;
    logic [15:0] exp_in = '0;
    logic [15:0] exp_dac = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytebus_dac_if #(.BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data(data),
        .iorq_n(iorq_n), .wr_n(wr_n), .dac_code(dac_code), .dac_upd(dac_upd)
    );

    always @(posedge clk) if (dac_upd) pulses <= pulses + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one bus cycle; mode 0 both strobes, 1 iorq only, 2 wr only
    task automatic bus(input logic [15:0] a, input logic [7:0] d,
                       input int mode, input int hold);
        @(negedge clk);
        addr = a; data = d;
        @(negedge clk);
        iorq_n = (mode == 2);
        wr_n   = (mode == 1);
        repeat (hold) @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // model an accepted write at offset o, then compare
    task automatic wr_chk(input string req, input logic [2:0] o, input logic [7:0] d);
        int p0;
        int exp_p;
        p0 = pulses;
        bus(BASE | 16'(o), d, 0, 4);
        exp_p = 0;
        case (o)
            3'd0: exp_in[7:0] = d;
            3'd1: exp_in[15:8] = d;
            3'd2, 3'd3: begin exp_dac = exp_in; exp_p = 1; end
            3'd4: begin exp_in = 16'h0000; exp_dac = 16'h0000; exp_p = 1; end
            3'd5: begin exp_in = 16'h8000; exp_dac = 16'h8000; exp_p = 1; end
            default: ;
        endcase
        check(req, int'(dac_code), int'(exp_dac));
        check({req, " R10 pulses"}, pulses - p0, exp_p);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_fail++; n_checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        check("R11 reset code", int'(dac_code), 0);
        check("R11 reset pulse", int'(dac_upd), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        wr_chk("R11 update after reset R3", 3'd2, 8'hA5);

        // R2 R3: sweep byte patterns, using both update offsets
        for (int k = 0; k < 48; k++) begin
            logic [7:0] lo, hi;
            lo = 8'((k * 37 + 11) & 8'hFF);
            hi = 8'((k * 91 + 200) & 8'hFF);
            wr_chk("R2 low byte", 3'd0, lo);
            wr_chk("R2 high byte", 3'd1, hi);
            wr_chk("R3 update", (k % 2 == 0) ? 3'd2 : 3'd3, 8'(k));
            check("R3 word", int'(dac_code), int'({hi, lo}));
        end

        // R4 R5 R6: clears with varied data, then update without reloads
        for (int k = 0; k < 8; k++) begin
            wr_chk("R2 low", 3'd0, 8'h3C ^ 8'(k));
            wr_chk("R2 high", 3'd1, 8'h7E ^ 8'(k));
            wr_chk("R4 R6 clear unipolar", 3'd4, 8'(k * 33));
            check("R4 value", int'(dac_code), 16'h0000);
            wr_chk("R4 input cleared R3", 3'd2, 8'hFF);
            check("R4 word kept", int'(dac_code), 16'h0000);
            wr_chk("R5 R6 clear bipolar", 3'd5, 8'(k * 77));
            check("R5 value", int'(dac_code), 16'h8000);
            wr_chk("R2 low after clear", 3'd0, 8'h12);
            wr_chk("R5 high kept R3", 3'd3, 8'h00);
            check("R5 merge", int'(dac_code), 16'h8012);
        end

        // R7: offsets 6 and 7 inert, checked through a later update
        wr_chk("R2 setup", 3'd0, 8'h55);
        wr_chk("R2 setup", 3'd1, 8'hAA);
        wr_chk("R7 offset 6", 3'd6, 8'hFF);
        wr_chk("R7 offset 7", 3'd7, 8'h00);
        wr_chk("R7 unchanged input R3", 3'd2, 8'h00);
        check("R7 word", int'(dac_code), 16'hAA55);

        // R8: foreign addresses
        for (int k = 0; k < 6; k++) begin
            int p0;
            logic [15:0] a;
            a = (k < 3) ? (BASE ^ 16'(8 << k)) | 16'd4 : (BASE ^ 16'(16'h1000 << (k - 3))) | 16'd5;
            p0 = pulses;
            bus(a, 8'h99, 0, 4);
            check("R8 foreign clear ignored", int'(dac_code), 16'hAA55);
            check("R8 no pulse", pulses - p0, 0);
        end
        bus(BASE | 16'd0, 8'h00, 0, 4);
        exp_in[7:0] = 8'h00;
        begin
            int p0;
            p0 = pulses;
            bus(BASE ^ 16'h0008, 8'h77, 0, 4);
            wr_chk("R8 foreign load ignored R3", 3'd2, 8'h00);
            check("R8 word", int'(dac_code), 16'hAA00);
            check("R8 single pulse", pulses - p0, 1);
        end

        // R1: single strobes do nothing
        begin
            int p0;
            p0 = pulses;
            bus(BASE | 16'd4, 8'h00, 1, 6);
            check("R1 iorq only", int'(dac_code), 16'hAA00);
            bus(BASE | 16'd5, 8'h00, 2, 6);
            check("R1 wr only", int'(dac_code), 16'hAA00);
            bus(BASE | 16'd0, 8'h11, 1, 6);
            bus(BASE | 16'd1, 8'h22, 2, 6);
            check("R1 no pulse", pulses - p0, 0);
            wr_chk("R1 loads blocked R3", 3'd2, 8'h00);
            check("R1 word", int'(dac_code), 16'hAA00);
        end

        // R9: long strobe gives one command
        begin
            int p0;
            wr_chk("R9 setup", 3'd0, 8'h01);
            p0 = pulses;
            bus(BASE | 16'd5, 8'h00, 0, 40);
            exp_in = 16'h8000; exp_dac = 16'h8000;
            check("R9 one pulse", pulses - p0, 1);
            check("R9 value", int'(dac_code), 16'h8000);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule